// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block connects the four shared PCI interrupt lines of a host bridge to processor interrupt inputs. It has two halves. The first half is a purely combinational lookup used during bus enumeration. It takes a device slot number and the interrupt-pin value read from that device's configuration header. It rotates the pin by the two low slot bits and returns the system interrupt number stored for the resulting line. The second half is the physical routing. Four routing ports each watch one of sixteen general-purpose input pins for an active-low level, and drive one of the system interrupt lines 4 to 7.

Software programs the block through a single-cycle register write port. It can write the line table, the port bytes and the pin-direction mask directly. It can also issue one setup command that names a system interrupt and a pin. A small sequencer then arms the matching port in three ordered steps. It has four states. In `ST_IDLE` it accepts writes. A valid command moves it to `ST_CLEAR`, where the port byte is zeroed. It then moves to `ST_INPUT`, where the chosen pin is made an input. Next comes `ST_ARM`, where the port byte is written with its enable bit and pin index. It then returns to `ST_IDLE`. An invalid command leaves it in `ST_IDLE`.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, all four line-table bytes are 0xFF, every port byte is 0, every direction bit is 1 (output), and `sys_irq` is 0 whatever `gpio_in` holds.
- R2: For `lk_pin` from 1 to 4, `lk_irq` equals line-table byte k, where k = ((lk_pin - 1) + lk_slot[1:0]) mod 4. `lk_irq` updates combinationally.
- R3: For any `lk_pin` other than 1 to 4, `lk_irq` is 0.
- R4: A write to address 0 loads the line table. Byte k (bits 8k+7..8k) is the entry for line k, with A = 0 through D = 3. An entry of 0xFF is returned unchanged and means "not assigned".
- R5: A write to address 1 loads the port bytes. The byte at bits 8n+7..8n configures port n, and port n drives `sys_irq[n]`, which is system interrupt 4+n. Bit 7 of the byte enables the port, bits 3..0 select the pin, and bits 6..4 are ignored.
- R6: An enabled port whose selected pin is an input asserts its `sys_irq` bit while that pin is low, and releases it while the pin is high. A change on `gpio_in` reaches `sys_irq` on the second rising clock edge after it, through a two-flop synchronizer.
- R7: A write to address 2 loads the direction mask from `cfg_wdata[15:0]`, with 1 meaning output. A port whose selected pin is an output never asserts.
- R8: A write to address 3 is a setup command. `cfg_wdata[7:0]` is the system interrupt number and `cfg_wdata[15:8]` is the pin index. If the pin index is below 16 and the interrupt number is 4 to 7, the port (number - 4) byte is cleared on the next edge. The pin's direction bit is cleared on the edge after that. On the third edge the port byte is set to enable plus pin index.
- R9: A setup command with a pin index of 16 or more, or with an interrupt number outside 4 to 7, changes no state.
- R10: While the sequencer is in `ST_CLEAR`, `ST_INPUT` or `ST_ARM`, every write on the configuration port is ignored.
- R11: A port whose enable bit is 0 never asserts, even when its pin is a low input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 2 | Register select: 0 line table, 1 port bytes, 2 direction, 3 setup command |
| cfg_wdata | input | 32 | Configuration write data |
| lk_slot | input | 5 | Device slot number for the lookup |
| lk_pin | input | 8 | Interrupt-pin value from the device header |
| lk_irq | output | 8 | System interrupt number for the device, 0 if the pin value is invalid |
| gpio_in | input | 16 | Asynchronous general-purpose input pins |
| sys_irq | output | 4 | Level interrupts; bit n is system interrupt 4+n |

## Verification
The assertions assume that `cfg_we` is a clean one-cycle strobe, with address and data stable in the same cycle. They also assume that `lk_pin` and `lk_slot` settle before the clock edge at which they are sampled. The bench drives every input on the falling edge and holds each write for exactly one cycle. It changes `gpio_in` only on falling edges as well, so the synchronizer latency it expects is deterministic. Writes issued during a setup sequence are placed deliberately one cycle after the command, so that the ignored-write rule is exercised inside the busy window rather than next to it.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;

    // Number of general-purpose input pins a port may select
    localparam int N_PINS   = 16;
    // Number of routing ports, one byte each in a 32-bit register
    localparam int N_PORTS  = 4;
    // Number of shared PCI interrupt lines (A..D)
    localparam int N_LINES  = 4;
    // First system interrupt served by the routing ports
    localparam int IRQ_BASE = 4;
    localparam int PIN_W    = $clog2(N_PINS);
    localparam int PORT_W   = $clog2(N_PORTS);
    localparam int EN_BIT   = 7;

    localparam logic [1:0] ADDR_TABLE = 2'd0;
    localparam logic [1:0] ADDR_PORT  = 2'd1;
    localparam logic [1:0] ADDR_DIR   = 2'd2;
    localparam logic [1:0] ADDR_SETUP = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_INPUT = 2'd2,
        ST_ARM   = 2'd3
    } setup_state_t;

endpackage

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle
    import pci_irq_pkg::*;
(
    input  logic [8*N_LINES-1:0] table_q,
    input  logic [1:0]           slot_lo,
    input  logic [7:0]           pin_val,
    output logic [7:0]           irq_num
);

    logic       pin_ok;
    logic [1:0] line_idx;

    always_comb begin
        pin_ok   = (pin_val >= 8'd1) && (pin_val <= 8'(N_LINES));
        // rotate by slot: pin 4 maps to raw index 3 through modulo-4 wrap
        line_idx = 2'(pin_val[1:0] - 2'd1 + slot_lo);
        irq_num  = pin_ok ? table_q[8*line_idx +: 8] : 8'd0;
    end

endmodule

// File: rtl/pci_irq_sync.sv
module pci_irq_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // idle level of an active-low line is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pci_irq_port.sv
module pci_irq_port
    import pci_irq_pkg::*;
(
    input  logic [7:0]        cfg_byte,
    input  logic [N_PINS-1:0] pins_sync,
    input  logic [N_PINS-1:0] dir_mask,
    output logic              irq_out
);

    logic [PIN_W-1:0] sel;

    always_comb begin
        sel     = cfg_byte[PIN_W-1:0];
        irq_out = cfg_byte[EN_BIT] & ~dir_mask[sel] & ~pins_sync[sel];
    end

endmodule

// File: rtl/pci_irq_cfg.sv
module pci_irq_cfg
    import pci_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [8*N_LINES-1:0] table_q,
    output logic [8*N_PORTS-1:0] port_q,
    output logic [N_PINS-1:0]    dir_q,
    output setup_state_t         state_q
);

    setup_state_t      state_d;
    logic [7:0]        cmd_irq;
    logic [7:0]        cmd_pin;
    logic              cmd_ok;
    logic              cmd_go;
    logic [PORT_W-1:0] tgt_port;
    logic [PIN_W-1:0]  tgt_pin;

    always_comb begin
        cmd_irq = cfg_wdata[7:0];
        cmd_pin = cfg_wdata[15:8];
        cmd_ok  = (cmd_pin < 8'(N_PINS)) &&
                  (cmd_irq >= 8'(IRQ_BASE)) &&
                  (cmd_irq <  8'(IRQ_BASE + N_PORTS));
        cmd_go  = (state_q == ST_IDLE) && cfg_we &&
                  (cfg_addr == ADDR_SETUP) && cmd_ok;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_go) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_INPUT;
            ST_INPUT: state_d = ST_ARM;
            ST_ARM:   state_d = ST_IDLE;
        endcase
    end

    // register contents, driven by writes in idle and by the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_q  <= '1;
            port_q   <= '0;
            dir_q    <= '1;
            tgt_port <= '0;
            tgt_pin  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_we) begin
                        unique case (cfg_addr)
                            ADDR_TABLE: table_q <= cfg_wdata[8*N_LINES-1:0];
                            ADDR_PORT:  port_q  <= cfg_wdata[8*N_PORTS-1:0];
                            ADDR_DIR:   dir_q   <= cfg_wdata[N_PINS-1:0];
                            ADDR_SETUP: begin
                                if (cmd_ok) begin
                                    tgt_port <= PORT_W'(cmd_irq - 8'(IRQ_BASE));
                                    tgt_pin  <= cmd_pin[PIN_W-1:0];
                                end
                            end
                        endcase
                    end
                end
                ST_CLEAR: port_q[8*tgt_port +: 8] <= 8'd0;
                ST_INPUT: dir_q[tgt_pin] <= 1'b0;
                ST_ARM:   port_q[8*tgt_port +: 8] <=
                              {1'b1, {(7-PIN_W){1'b0}}, tgt_pin};
            endcase
        end
    end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pci_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [4:0]        lk_slot,
    input  logic [7:0]        lk_pin,
    output logic [7:0]        lk_irq,
    input  logic [N_PINS-1:0] gpio_in,
    output logic [N_PORTS-1:0] sys_irq
);

    logic [8*N_LINES-1:0] table_q;
    logic [8*N_PORTS-1:0] port_q;
    logic [N_PINS-1:0]    dir_q;
    logic [N_PINS-1:0]    pins_sync;
    setup_state_t         setup_state;
    logic [2:0]           slot_hi_unused;

    assign slot_hi_unused = lk_slot[4:2];

    pci_irq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .table_q  (table_q),
        .port_q   (port_q),
        .dir_q    (dir_q),
        .state_q  (setup_state)
    );

    pci_irq_swizzle u_swz (
        .table_q (table_q),
        .slot_lo (lk_slot[1:0]),
        .pin_val (lk_pin),
        .irq_num (lk_irq)
    );

    pci_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(gpio_in),
        .sync_out(pins_sync)
    );

    for (genvar n = 0; n < N_PORTS; n++) begin : g_port
        pci_irq_port u_port (
            .cfg_byte (port_q[8*n +: 8]),
            .pins_sync(pins_sync),
            .dir_mask (dir_q),
            .irq_out  (sys_irq[n])
        );
    end

endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk
    import pci_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [1:0]           cfg_addr,
    input logic [15:0]          cfg_cmd,
    input logic [7:0]           lk_pin,
    input logic [7:0]           lk_irq,
    input logic [N_PORTS-1:0]   sys_irq,
    input logic [1:0]           state_q,
    input logic [8*N_PORTS-1:0] port_q,
    input logic [N_PINS-1:0]    dir_q
);

    logic bad_cmd;
    assign bad_cmd = (cfg_cmd[15:8] >= 8'(N_PINS)) ||
                     (cfg_cmd[7:0] < 8'(IRQ_BASE)) ||
                     (cfg_cmd[7:0] >= 8'(IRQ_BASE + N_PORTS));

    AST_LOOKUP_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_pin == 8'd0) || (lk_pin > 8'(N_LINES))) |-> (lk_irq == 8'd0)); // R3

    AST_CLEAR_THEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (state_q == ST_INPUT)); // R8

    AST_INPUT_THEN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INPUT) |=> (state_q == ST_ARM)); // R8

    AST_ARM_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> (state_q == ST_IDLE)); // R8

    AST_BAD_CMD_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && cfg_we && (cfg_addr == ADDR_SETUP) && bad_cmd)
        |=> (state_q == ST_IDLE)); // R9

    AST_BUSY_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CLEAR) || (state_q == ST_ARM)) |=> $stable(dir_q)); // R10

    for (genvar n = 0; n < N_PORTS; n++) begin : g_chk
        AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            sys_irq[n] |-> port_q[8*n + EN_BIT]); // R11

        AST_IRQ_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            sys_irq[n] |-> !dir_q[port_q[8*n +: PIN_W]]); // R7
    end

endmodule

bind pci_irq_router pci_irq_router_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .cfg_cmd (cfg_wdata[15:0]),
    .lk_pin  (lk_pin),
    .lk_irq  (lk_irq),
    .sys_irq (sys_irq),
    .state_q (setup_state),
    .port_q  (port_q),
    .dir_q   (dir_q)
);

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [4:0]  lk_slot = '0;
    logic [7:0]  lk_pin = '0;
    logic [7:0]  lk_irq;
    logic [15:0] gpio_in = '0;
    logic [3:0]  sys_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_irq_router uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .lk_slot  (lk_slot),
        .lk_pin   (lk_pin),
        .lk_irq   (lk_irq),
        .gpio_in  (gpio_in),
        .sys_irq  (sys_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [4:0] s, input logic [7:0] p, input logic [7:0] exp, input string req);
        lk_slot = s; lk_pin = p;
        #1;
        chk(req, {24'd0, lk_irq}, {24'd0, exp});
    endtask

    task automatic edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 sys_irq at reset", {28'd0, sys_irq}, 32'h0);
        look(5'd0, 8'd1, 8'hFF, "R1 table reset 0xFF");
        look(5'd2, 8'd4, 8'hFF, "R1 table reset 0xFF line");
    endtask

    task automatic t_lookup;
        wr(2'd0, 32'h44332211);          // R4: A=11 B=22 C=33 D=44
        look(5'd0, 8'd1, 8'h11, "R4 slot0 pin1");
        look(5'd1, 8'd1, 8'h22, "R2 slot1 pin1");
        look(5'd3, 8'd2, 8'h11, "R2 slot3 pin2 wrap");
        look(5'd6, 8'd4, 8'h22, "R2 slot6 pin4");
        look(5'd5, 8'd3, 8'h44, "R2 slot5 pin3");
        wr(2'd0, 32'h44FF2211);
        look(5'd0, 8'd3, 8'hFF, "R4 unassigned entry");
    endtask

    task automatic t_bad_pin;
        look(5'd1, 8'd0, 8'h00, "R3 pin 0");
        look(5'd1, 8'd5, 8'h00, "R3 pin 5");
        look(5'd2, 8'hFF, 8'h00, "R3 pin 255");
    endtask

    task automatic t_route;
        gpio_in = 16'hFFFF;
        wr(2'd2, 32'h0);                 // all inputs
        wr(2'd1, 32'h008F_0083);         // port0 pin3, port2 pin15
        edges(2);
        chk("R6 idle high", {28'd0, sys_irq}, 32'h0);
        gpio_in[3] = 1'b0;
        gpio_in[4] = 1'b0;
        edges(1);
        chk("R6 one edge latency", {28'd0, sys_irq}, 32'h0);
        edges(1);
        chk("R5 R6 port0 asserts", {28'd0, sys_irq}, 32'h1);
        gpio_in[15] = 1'b0;
        edges(2);
        chk("R5 port2 asserts", {28'd0, sys_irq}, 32'h5);
        gpio_in[3] = 1'b1;
        edges(2);
        chk("R6 release on high", {28'd0, sys_irq}, 32'h4);
        gpio_in[3] = 1'b0;
        edges(2);
    endtask

    task automatic t_direction;
        wr(2'd2, 32'h0000_0008);         // pin3 output
        chk("R7 output pin blocks", {28'd0, sys_irq}, 32'h4);
        wr(2'd2, 32'h0);
        chk("R7 input again", {28'd0, sys_irq}, 32'h5);
    endtask

    task automatic t_disable;
        wr(2'd1, 32'h0000_0003);         // port0 pin3 not enabled
        chk("R11 disabled port", {28'd0, sys_irq}, 32'h0);
        wr(2'd1, 32'h0000_00F3);         // bits 6..4 ignored
        chk("R5 ignored bits", {28'd0, sys_irq}, 32'h1);
    endtask

    task automatic t_setup;
        gpio_in = 16'hFFFF;
        gpio_in[2] = 1'b0;
        gpio_in[9] = 1'b0;
        wr(2'd1, 32'h0000_8200);         // port1 pin2
        wr(2'd2, 32'h0000_FFFB);         // only pin2 input
        edges(2);
        chk("R8 before setup", {28'd0, sys_irq}, 32'h2);
        wr(2'd3, 32'h0000_0905);         // irq5 pin9
        edges(1);
        chk("R8 byte cleared", {28'd0, sys_irq}, 32'h0);
        edges(1);
        chk("R8 not yet armed", {28'd0, sys_irq}, 32'h0);
        edges(1);
        chk("R8 armed pin9", {28'd0, sys_irq}, 32'h2);
    endtask

    task automatic t_reject;
        gpio_in = 16'hFFFF;
        gpio_in[1] = 1'b0;
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0000_0081);         // port0 pin1
        edges(2);
        chk("R9 baseline", {28'd0, sys_irq}, 32'h1);
        wr(2'd3, 32'h0000_1004);         // pin16 invalid
        edges(4);
        chk("R9 pin16 rejected", {28'd0, sys_irq}, 32'h1);
        wr(2'd3, 32'h0000_0103);         // irq3 invalid
        edges(4);
        chk("R9 irq3 rejected", {28'd0, sys_irq}, 32'h1);
        wr(2'd3, 32'h0000_0108);         // irq8 invalid
        edges(4);
        chk("R9 irq8 rejected", {28'd0, sys_irq}, 32'h1);
    endtask

    task automatic t_busy;
        gpio_in = 16'hFFFF;
        gpio_in[7] = 1'b0;
        wr(2'd1, 32'h0);
        wr(2'd3, 32'h0000_0706);         // irq6 pin7
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h0000_FFFF;
        @(negedge clk);                  // lands in ST_CLEAR
        cfg_addr = 2'd1; cfg_wdata = 32'h0000_0087;
        @(negedge clk);                  // lands in ST_INPUT
        cfg_we = 1'b0;
        edges(3);
        chk("R10 writes in busy ignored", {28'd0, sys_irq}, 32'h4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        edges(3);
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        edges(2);
        t_reset;
        t_lookup;
        t_bad_pin;
        t_route;
        t_direction;
        t_disable;
        t_setup;
        t_reject;
        t_busy;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule